// File: doc/BRIEF.md
# DRAM Refresh and Parallel-Test Cycle Decoder

This block sits on the memory side of a multiplexed-address DRAM and watches the sampled row strobe, column strobe and write strobe. At every falling row strobe it decides what kind of cycle has started. A cycle with the column strobe already low is a refresh that takes its row from an internal counter. A cycle with the column strobe high opens the row on the address bus. That row cycle is either a normal access, if the column strobe later falls, or a row-only refresh, if the row strobe rises first. The block hands the array the row to activate, the latched column and a write pulse. It drives the read data back through a per-DQ selector.

A refresh taken with the write strobe low also puts the part into a parallel test mode. In this mode the two lowest column bits are dropped, so each DQ writes four cells at once. On a read, each DQ reports whether its four cells agree. Either a refresh taken with the write strobe high or a completed row-only refresh leaves test mode. The column strobe can stay low after a read while the row strobe cycles again. That cycle is a hidden refresh: the output stays on and keeps its value.

The cycle controller has six states. ST_IDLE is the state with the row strobe high. ST_ROW holds an opened row before any column strobe. ST_ACC is a column access, ST_PRE holds read data after the row closes, ST_CBR is a counter refresh from idle, and ST_HID is a counter refresh entered from ST_PRE. Its transitions are as follows:
- ST_IDLE goes to ST_ROW when the row strobe falls with the column strobe high, and to ST_CBR when it falls with the column strobe low.
- ST_ROW goes to ST_ACC when the column strobe falls, and back to ST_IDLE when the row strobe rises.
- ST_ACC goes to ST_PRE when the row strobe rises with the column strobe low, and to ST_IDLE when it rises with the column strobe high.
- ST_PRE goes to ST_HID when the row strobe falls with the column strobe low, to ST_ROW when it falls with the column strobe high, and to ST_IDLE when the column strobe rises.
- ST_CBR goes to ST_IDLE when the row strobe rises.
- ST_HID goes to ST_PRE or ST_IDLE when the row strobe rises, depending on the column strobe.

Top module: `dram_refresh_decoder`

## Requirements
- R1: After reset, test_mode, act_pulse, act_refresh, wr_strobe and dq_oe are 0, and the first counter refresh uses row 0.
- R2: A falling row strobe sampled with the column strobe low pulses act_pulse for one cycle with act_refresh=1, and act_row is the counter value; addr is ignored.
- R3: The counter advances by one on each counter refresh, and it wraps from 4095 to 0.
- R4: A falling row strobe sampled with the column strobe high pulses act_pulse with act_refresh=0 and act_row equal to addr at that sample. If no column strobe follows, dq_oe stays 0.
- R5: Back-to-back counter refreshes with the column strobe held low, and only the row strobe toggling, each produce a refresh.
- R6: A hidden refresh (the column strobe held low after a read, the row strobe rising and falling again) is a counter refresh. dq_oe stays 1 and dq_out keeps its value through it.
- R7: A counter refresh sampled with the write strobe low sets test_mode in the same cycle as its act_pulse.
- R8: test_mode is cleared by a counter refresh with the write strobe high, or by a row strobe rise in a row cycle that had no column strobe. Normal accesses leave it unchanged.
- R9: In a normal read, col_addr latches addr[9:0] on the column strobe fall. One cycle later dq_oe=1 and dq_out[i]=rd_bits[4*i+col_addr[1:0]].
- R10: In test mode, col_addr[1:0] latches as 0, and dq_out[i] is 1 exactly when rd_bits[4*i+3:4*i] are all equal.
- R11: While the row stays low, a rising column strobe keeps dq_out and dq_oe. A new column strobe fall latches a new column, and its data appears one cycle after the old data.
- R12: wr_strobe pulses for one cycle on a column strobe fall with the write strobe low, or on a write strobe fall while the column strobe is low. Either clears dq_oe for the rest of that access.
- R13: Every output changes only on the clock edge that samples the causing strobe transition; act_pulse never stays high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write strobe, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| rd_bits | input | DQ_W*PAR | Cells read from the array, PAR per DQ, cell j of DQ i at bit PAR*i+j |
| act_pulse | output | 1 | One-cycle pulse: a row is being activated |
| act_refresh | output | 1 | Activated row came from the internal counter |
| act_row | output | ROW_W | Row to activate |
| col_addr | output | COL_W | Latched column, low bits zero in test mode |
| wr_strobe | output | 1 | One-cycle write pulse to the array |
| test_mode | output | 1 | Parallel test mode active |
| dq_out | output | DQ_W | Read data, selected or folded |
| dq_oe | output | 1 | Read data valid and driven |

## Verification
If the internal refresh counter is wrong, it shows on act_row at the very next counter refresh. If the cycle state is wrong, it shows at the next strobe edge as a wrong act_refresh, a missing write pulse or a dq_oe that drops during a hidden refresh. A stale test flag only appears when a column is latched (low bits not cleared) or read (a select instead of a fold). For this reason the bench reads after every mode change. A reference model running beside the design compares every output on every clock, so a divergence is reported within one cycle of the edge that caused it.

// File: rtl/drd_pkg.sv
package drd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_ACC,
        ST_PRE,
        ST_CBR,
        ST_HID
    } cyc_st_t;
endpackage

// File: rtl/strobe_edges.sv
module strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic we_fall
);
    logic ras_q, cas_q, we_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    assign ras_fall = ras_q & ~ras_n;
    assign ras_rise = ~ras_q & ras_n;
    assign cas_fall = cas_q & ~cas_n;
    assign we_fall  = we_q & ~we_n;
endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (step)
            value <= value + 1'b1;
    end
endmodule

// File: rtl/dq_fold.sv
module dq_fold #(
    parameter int DQ_W = 4,
    parameter int PAR  = 4,
    localparam int SEL_W = $clog2(PAR)
) (
    input  logic [DQ_W*PAR-1:0] bits,
    input  logic [SEL_W-1:0]    sel,
    input  logic                par_mode,
    output logic [DQ_W-1:0]     dq
);
    for (genvar i = 0; i < DQ_W; i++) begin : g_dq
        logic [PAR-1:0] grp;
        assign grp   = bits[i*PAR +: PAR];
        assign dq[i] = par_mode ? ((&grp) | ~(|grp)) : grp[sel];
    end
endmodule

// File: rtl/dram_refresh_decoder.sv
module dram_refresh_decoder
    import drd_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    parameter int DQ_W  = 4,
    parameter int PAR   = 4,
    localparam int SEL_W = $clog2(PAR)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic [ROW_W-1:0]    addr,
    input  logic [DQ_W*PAR-1:0] rd_bits,
    output logic                act_pulse,
    output logic                act_refresh,
    output logic [ROW_W-1:0]    act_row,
    output logic [COL_W-1:0]    col_addr,
    output logic                wr_strobe,
    output logic                test_mode,
    output logic [DQ_W-1:0]     dq_out,
    output logic                dq_oe
);
    cyc_st_t          state_q, state_d;
    logic             ras_fall, ras_rise, cas_fall, we_fall;
    logic [ROW_W-1:0] ctr_val;
    logic [DQ_W-1:0]  fold_dq;
    logic             rd_on, dq_valid, col_edge, ctr_step;

    strobe_edges u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall), .we_fall(we_fall)
    );

    assign ctr_step = ras_fall & ~cas_n;

    refresh_ctr #(.W(ROW_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .step(ctr_step), .value(ctr_val)
    );

    dq_fold #(.DQ_W(DQ_W), .PAR(PAR)) u_fold (
        .bits(rd_bits), .sel(col_addr[SEL_W-1:0]), .par_mode(test_mode), .dq(fold_dq)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ras_fall) state_d = cas_n ? ST_ROW : ST_CBR;
            ST_PRE: begin
                if (ras_fall)   state_d = cas_n ? ST_ROW : ST_HID;
                else if (cas_n) state_d = ST_IDLE;
            end
            ST_ROW: begin
                if (ras_rise)    state_d = ST_IDLE;
                else if (!cas_n) state_d = ST_ACC;
            end
            ST_ACC:  if (ras_rise) state_d = cas_n ? ST_IDLE : ST_PRE;
            ST_CBR:  if (ras_rise) state_d = ST_IDLE;
            ST_HID:  if (ras_rise) state_d = cas_n ? ST_IDLE : ST_PRE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign col_edge = ((state_q == ST_ROW) || (state_q == ST_ACC)) && cas_fall;

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_pulse   <= 1'b0;
            act_refresh <= 1'b0;
            act_row     <= '0;
            col_addr    <= '0;
            wr_strobe   <= 1'b0;
            test_mode   <= 1'b0;
            dq_out      <= '0;
            rd_on       <= 1'b0;
            dq_valid    <= 1'b0;
        end else begin
            act_pulse <= 1'b0;
            wr_strobe <= 1'b0;
            if (ras_fall) begin
                act_pulse   <= 1'b1;
                act_refresh <= ~cas_n;
                act_row     <= cas_n ? addr : ctr_val;
                if (!cas_n) test_mode <= ~we_n;
            end
            if ((state_q == ST_ROW) && ras_rise) test_mode <= 1'b0;
            if ((state_q == ST_ACC) && !cas_n && !cas_fall) begin
                dq_out   <= fold_dq;
                dq_valid <= 1'b1;
            end
            if ((state_q == ST_ACC) && !we_n) rd_on <= 1'b0;
            if (col_edge) begin
                col_addr  <= test_mode ? {addr[COL_W-1:SEL_W], {SEL_W{1'b0}}}
                                       : addr[COL_W-1:0];
                rd_on     <= we_n;
                wr_strobe <= ~we_n;
            end else if ((state_q == ST_ACC) && !cas_n && we_fall) begin
                wr_strobe <= 1'b1;
            end
            if ((state_d == ST_IDLE) || (state_d == ST_ROW) || (state_d == ST_CBR)) begin
                rd_on    <= 1'b0;
                dq_valid <= 1'b0;
            end
        end
    end

    assign dq_oe = rd_on & dq_valid &
                   ((state_q == ST_ACC) || (state_q == ST_PRE) || (state_q == ST_HID));
endmodule

// File: rtl/dram_refresh_decoder_chk.sv
module dram_refresh_decoder_chk #(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [ROW_W-1:0] addr,
    input logic             act_pulse,
    input logic             act_refresh,
    input logic [ROW_W-1:0] act_row,
    input logic [COL_W-1:0] col_addr,
    input logic             wr_strobe,
    input logic             test_mode,
    input logic             dq_oe
);
    logic [ROW_W-1:0] last_ref;
    logic             seen_ref;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ref <= '0;
            seen_ref <= 1'b0;
        end else if (act_pulse && act_refresh) begin
            last_ref <= act_row;
            seen_ref <= 1'b1;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |=> !act_pulse); // R13
    AST_ROWONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pulse && !act_refresh) |-> act_row == $past(addr)); // R4
    AST_ROWONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pulse && !act_refresh) |-> !dq_oe); // R4
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pulse && act_refresh && seen_ref) |-> act_row == ROW_W'(last_ref + 1'b1)); // R3
    AST_TM_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> (act_pulse && act_refresh)); // R7
    AST_TM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> ((act_pulse && act_refresh) || ($past(ras_n) && !$past(ras_n, 2)))); // R8
    AST_TM_COLMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && wr_strobe) |-> col_addr[SEL_W-1:0] == '0); // R10
endmodule

bind dram_refresh_decoder dram_refresh_decoder_chk #(
    .ROW_W(ROW_W), .COL_W(COL_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .addr(addr),
    .act_pulse(act_pulse), .act_refresh(act_refresh), .act_row(act_row),
    .col_addr(col_addr), .wr_strobe(wr_strobe), .test_mode(test_mode), .dq_oe(dq_oe)
);

// File: tb/sim_dram_refresh_decoder.sv
`timescale 1ns/1ps
module sim_dram_refresh_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic [15:0] rd_bits;
    logic        act_pulse, act_refresh, wr_strobe, test_mode, dq_oe;
    logic [11:0] act_row;
    logic [9:0]  col_addr;
    logic [3:0]  dq_out;

    int n_cmp = 0, n_bad = 0, n_ref = 0;
    logic [3:0] mem [1024];

    always #4 clk = ~clk;

    dram_refresh_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .rd_bits(rd_bits), .act_pulse(act_pulse), .act_refresh(act_refresh),
        .act_row(act_row), .col_addr(col_addr), .wr_strobe(wr_strobe),
        .test_mode(test_mode), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // behavioural array: cell j of DQ i at rd_bits[4*i+j]
    always_comb begin
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                rd_bits[i*4+j] = mem[{col_addr[9:2], 2'(j)}][i];
    end

    always @(negedge clk) begin
        if (rst_n && wr_strobe) begin
            if (test_mode)
                for (int j = 0; j < 4; j++) mem[{col_addr[9:2], 2'(j)}] = wdata;
            else
                mem[col_addr] = wdata;
        end
    end

    function automatic logic [3:0] ref_read(logic [9:0] c, bit tm);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            int ones = 0;
            for (int j = 0; j < 4; j++) ones += mem[{c[9:2], 2'(j)}][i];
            r[i] = tm ? (ones == 0 || ones == 4) : mem[c][i];
        end
        return r;
    endfunction

    // reference model, cycle level
    bit pr = 1, pc = 1, pw = 1;
    int ph = 0; // 0 idle 1 row 2 access 3 hold 4 refresh 5 hidden
    logic [11:0] m_cnt = 0, m_row = 0;
    logic [9:0]  m_col = 0;
    logic [3:0]  m_dq = 0;
    bit m_pulse = 0, m_ref = 0, m_tm = 0, m_rdon = 0, m_dv = 0, m_wr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pr = 1; pc = 1; pw = 1; ph = 0; m_cnt = 0; m_row = 0; m_col = 0; m_dq = 0;
            m_pulse = 0; m_ref = 0; m_tm = 0; m_rdon = 0; m_dv = 0; m_wr = 0;
        end else begin
            bit rf, rr, cf, wf;
            int nph;
            rf = pr && !ras_n; rr = !pr && ras_n; cf = pc && !cas_n; wf = pw && !we_n;
            nph = ph; m_pulse = 0; m_wr = 0;
            if (rf) begin
                m_pulse = 1; m_ref = !cas_n;
                if (cas_n) m_row = addr;
                else begin m_row = m_cnt; m_cnt = m_cnt + 1; m_tm = !we_n; end
                nph = cas_n ? 1 : (ph == 3 ? 5 : 4);
            end else begin
                case (ph)
                    1: if (rr) begin nph = 0; m_tm = 0; end else if (!cas_n) nph = 2;
                    2: if (rr) nph = cas_n ? 0 : 3;
                    3: if (cas_n) nph = 0;
                    4: if (rr) nph = 0;
                    5: if (rr) nph = cas_n ? 0 : 3;
                    default: nph = 0;
                endcase
            end
            if (ph == 2 && !cas_n && !cf) begin m_dq = ref_read(m_col, m_tm); m_dv = 1; end
            if (ph == 2 && !we_n) m_rdon = 0;
            if ((ph == 1 || ph == 2) && cf) begin
                m_col = m_tm ? {addr[9:2], 2'b00} : addr[9:0];
                m_rdon = we_n; m_wr = !we_n;
            end else if (ph == 2 && !cas_n && wf) m_wr = 1;
            if (nph == 0 || nph == 1 || nph == 4) begin m_rdon = 0; m_dv = 0; end
            ph = nph; pr = ras_n; pc = cas_n; pw = we_n;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    bit m_oe;
    always @(negedge clk) begin
        if (rst_n) begin
            m_oe = m_rdon && m_dv && (ph == 2 || ph == 3 || ph == 5);
            chk("R13 act_pulse", act_pulse, m_pulse);
            chk("R2 act_refresh", act_refresh, m_ref);
            chk("R3 act_row", act_row, m_row);
            chk("R7 test_mode", test_mode, m_tm);
            chk("R10 col_addr", col_addr, m_col);
            chk("R12 wr_strobe", wr_strobe, m_wr);
            chk("R6 dq_oe", dq_oe, m_oe);
            if (m_oe) chk("R9 dq_out", dq_out, m_dq);
        end
    end

    task automatic step(bit r, bit c, bit w, logic [11:0] a = '0, logic [3:0] d = '0);
        @(negedge clk); #1;
        ras_n = r; cas_n = c; we_n = w; addr = a; wdata = d;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic wr_col(logic [9:0] c, logic [3:0] d);
        step(0, 1, 1, 12'h0A0);
        step(0, 0, 0, 12'(c), d);
        step(1, 1, 1);
    endtask

    task automatic cbr(bit w);
        step(1, 0, w);
        step(0, 0, w);
        n_ref++;
    endtask

    bit done = 0;
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] held;
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        look();
        chk("R1 test_mode", test_mode, 0);
        chk("R1 dq_oe", dq_oe, 0);
        chk("R1 act_pulse", act_pulse, 0);

        // first counter refresh uses row 0, address ignored
        step(1, 0, 1, 12'hFFF);
        step(0, 0, 1, 12'hABC);
        n_ref++;
        look();
        chk("R1 first refresh row", act_row, 0);
        chk("R2 refresh flag", act_refresh, 1);
        step(1, 1, 1);

        // row-only refresh keeps outputs off
        step(0, 1, 1, 12'h5A5);
        look();
        chk("R4 row", act_row, 12'h5A5);
        chk("R4 flag", act_refresh, 0);
        step(0, 1, 1, 12'h5A5);
        look();
        chk("R4 quiet", dq_oe, 0);
        step(1, 1, 1);

        // normal writes (early write)
        wr_col(10'd3, 4'hA);
        wr_col(10'd4, 4'h5);
        wr_col(10'd8, 4'hF); wr_col(10'd9, 4'hF);
        wr_col(10'd10, 4'hF); wr_col(10'd11, 4'h7);

        // normal read, then EDO column change
        step(0, 1, 1, 12'h0A0);
        step(0, 0, 1, 12'd3);
        step(0, 0, 1, 12'd3);
        look();
        chk("R9 oe", dq_oe, 1);
        chk("R9 data col3", dq_out, 4'hA);
        step(0, 1, 1, 12'd4);
        look();
        chk("R11 hold during precharge", dq_out, 4'hA);
        chk("R11 oe during precharge", dq_oe, 1);
        step(0, 0, 1, 12'd4);
        step(0, 0, 1, 12'd4);
        look();
        chk("R11 new column data", dq_out, 4'h5);

        // hidden refresh keeps data
        held = dq_out;
        step(1, 0, 1);
        step(0, 0, 1, 12'h777);
        n_ref++;
        look();
        chk("R6 hidden refresh flag", act_refresh, 1);
        chk("R6 hidden oe", dq_oe, 1);
        chk("R6 hidden data", dq_out, held);
        step(1, 0, 1);
        step(0, 0, 1);
        n_ref++;
        look();
        chk("R6 second hidden oe", dq_oe, 1);
        step(1, 1, 1);

        // late write inside a read access
        step(0, 1, 1, 12'h0A0);
        step(0, 0, 1, 12'd5);
        step(0, 0, 0, 12'd5, 4'h3);
        look();
        chk("R12 late write pulse", wr_strobe, 1);
        step(1, 1, 1);
        look();
        chk("R12 late write stored", mem[5], 4'h3);

        // successive refreshes with CAS held low
        cbr(1); cbr(1); cbr(1);
        look();
        chk("R5 successive row", act_row, 12'(n_ref - 1));

        // enter test mode
        cbr(0);
        look();
        chk("R7 entered", test_mode, 1);
        step(1, 1, 1);
        // test-mode read: group 8..11, DQ3 disagrees
        step(0, 1, 1, 12'h0A0);
        step(0, 0, 1, 12'd9);
        step(0, 0, 1, 12'd9);
        look();
        chk("R10 col low bits", col_addr, 10'd8);
        chk("R10 fold", dq_out, 4'h7);
        step(1, 1, 1);
        chk("R8 access keeps mode", test_mode, 1);
        // parallel write to group 20..23
        wr_col(10'd21, 4'h9);
        step(0, 1, 1, 12'h0A0);
        step(0, 0, 1, 12'd22);
        step(0, 0, 1, 12'd22);
        look();
        chk("R10 fold agree", dq_out, 4'hF);
        step(1, 1, 1);
        // exit by row-only refresh
        step(0, 1, 1, 12'h111);
        step(1, 1, 1);
        look();
        chk("R8 exit row-only", test_mode, 0);
        step(0, 1, 1, 12'h0A0);
        step(0, 0, 1, 12'd20);
        step(0, 0, 1, 12'd20);
        look();
        chk("R10 parallel write stored", dq_out, 4'h9);
        step(1, 1, 1);
        // re-enter, exit by refresh with W high
        cbr(0);
        step(1, 1, 1);
        cbr(1);
        look();
        chk("R8 exit refresh", test_mode, 0);
        step(1, 1, 1);

        // counter wrap
        while ((n_ref % 4096) != 4095) cbr(1);
        look();
        cbr(1);
        look();
        chk("R3 row before wrap", act_row, 4095);
        cbr(1);
        look();
        chk("R3 wrap to zero", act_row, 0);
        step(1, 1, 1);
        look();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule